// File: doc/BRIEF.md
# Warp Issue Scheduler with Register Scoreboard

This block is one scheduling partition of a multithreaded shader core. It watches a pool of resident warps and, in every clock cycle, hands at most one of them to the execution pipes. Each warp presents its next decoded instruction to the block. The instruction carries two source register ids, a destination register id with a write flag, a target pipe code and a barrier flag. The block judges which warps could issue now, picks one of them fairly, and reports the choice in the same cycle. The front end consumes the issued instruction at the next rising edge.

Pending register writes are tracked per warp in a small scoreboard. Arithmetic and control results free their register after a fixed latency. Special-function results free it after a longer fixed latency. Load results stay pending until the memory side sends a completion pulse tagged with the warp and the register. Pipes with a slow issue rate stay closed for a few cycles after each dispatch. A warp that issues a barrier instruction is parked until every resident warp has reached the barrier. A profiling output gives the number of warps that could issue in the current cycle.

Top module: `warp_issue_sched`

## Requirements
- R1: `issue_valid` is high in a cycle exactly when at least one warp is eligible. `issue_warp` then names an eligible warp, and `issue_pipe` repeats that warp's pipe code (0 arithmetic, 1 special function, 2 load/store, 3 control). The instruction is consumed at the following rising edge.
- R2: A warp is eligible only when all of the following hold: its `warp_active` bit is set, its `inst_valid` bit is set, it is not parked at a barrier, neither source register has a pending write, its destination has no pending write when `inst_wr` is set, and its target pipe is open.
- R3: Arbitration is round-robin. The search starts one warp after the last issuer, so the warp that issued most recently has the lowest priority. A warp that is the only eligible one issues again. After reset the search starts at warp 0.
- R4: An instruction with `inst_wr` set on pipe 0 or 3 marks its destination pending. A dependent instruction from the same warp can issue 4 cycles after the producer (ALU_LAT), and not earlier.
- R5: A writing instruction on pipe 1 frees its destination 12 cycles after issue (SFU_LAT). Pipe 1 accepts a new instruction no sooner than 4 cycles after the previous one (SFU_II). Pipe 2 accepts one no sooner than 2 cycles after the previous one (LSU_II).
- R6: A writing instruction on pipe 2 keeps its destination pending until a `ld_done_valid` pulse arrives that carries the same warp id and register id. A dependent instruction can then issue in the next cycle. A pulse whose warp or register does not match leaves the entry pending.
- R7: A warp that issues with `inst_bar` set is parked. When every resident warp is parked, all are released at the next edge. The group is then eligible one cycle after the cycle in which the last warp was seen parked.
- R8: `elig_count` equals the number of eligible warps in the current cycle.
- R9: Reset clears every scoreboard bit, every barrier park bit, the pipe busy counters and the arbiter pointer.
- R10: Several scoreboard events on one edge all take effect: a load completion, a fixed-latency release and a new set that targets the same register index in another warp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| warp_active | input | NUM_WARPS | Resident warp mask; also the barrier group |
| inst_valid | input | NUM_WARPS | Next instruction of the warp is fetched and decoded |
| inst_src0 | input | NUM_WARPS*RID_W | First source register id per warp |
| inst_src1 | input | NUM_WARPS*RID_W | Second source register id per warp |
| inst_dst | input | NUM_WARPS*RID_W | Destination register id per warp |
| inst_wr | input | NUM_WARPS | Instruction writes its destination |
| inst_pipe | input | NUM_WARPS*2 | Target pipe code per warp |
| inst_bar | input | NUM_WARPS | Instruction is a barrier |
| ld_done_valid | input | 1 | Load completion pulse |
| ld_done_warp | input | WID_W | Warp id of the completed load |
| ld_done_reg | input | RID_W | Register id of the completed load |
| issue_valid | output | 1 | A warp issues this cycle |
| issue_warp | output | WID_W | Id of the issuing warp |
| issue_pipe | output | 2 | Pipe code of the issued instruction |
| elig_count | output | CNT_W | Number of eligible warps this cycle |

## Verification
Two kinds of scoreboard events can land on the same clock edge. One is a clear: a load completion pulse or the expiry of a fixed-latency release. The other is a set from a fresh issue that writes the same register index in a different warp. The bench provokes this directly. Warp 0 waits on a load register and on an arithmetic register. The bench times a completion pulse so that it falls on the edge where the arithmetic release expires, and warp 1 issues a write to the same register index on that same edge. The result is judged by observing issues at the ports: warp 0's dependent instruction must issue in the very next cycle, and warp 1's dependent instruction must still wait the full arithmetic latency.

// File: rtl/warp_sched_pkg.sv
package warp_sched_pkg;

    localparam int PIPE_W = 2;
    localparam int PIPE_N = 4;

    // Pipe codes seen on inst_pipe / issue_pipe
    typedef enum logic [PIPE_W-1:0] {
        PIPE_ALU  = 2'd0,
        PIPE_SFU  = 2'd1,
        PIPE_LSU  = 2'd2,
        PIPE_CTRL = 2'd3
    } pipe_e;

endpackage

// File: rtl/ws_scoreboard.sv
module ws_scoreboard
    import warp_sched_pkg::*;
#(
    parameter int NUM_WARPS = 16,
    parameter int NUM_REGS  = 8,
    parameter int ALU_LAT   = 4,
    parameter int SFU_LAT   = 12,
    localparam int WID_W    = $clog2(NUM_WARPS),
    localparam int RID_W    = $clog2(NUM_REGS),
    localparam int ALU_D    = ALU_LAT - 1,
    localparam int SFU_D    = SFU_LAT - 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          set_valid,
    input  logic [WID_W-1:0]              set_warp,
    input  logic [RID_W-1:0]              set_reg,
    input  pipe_e                         set_pipe,
    input  logic                          ld_done_valid,
    input  logic [WID_W-1:0]              ld_done_warp,
    input  logic [RID_W-1:0]              ld_done_reg,
    output logic [NUM_WARPS*NUM_REGS-1:0] pend
);

    typedef struct packed {
        logic             v;
        logic [WID_W-1:0] wid;
        logic [RID_W-1:0] rid;
    } rel_t;

    typedef struct packed {
        logic [NUM_WARPS-1:0][NUM_REGS-1:0] sb;
        rel_t [ALU_D-1:0]                   alu;
        rel_t [SFU_D-1:0]                   sfu;
    } sb_state_t;

    sb_state_t st_d, st_q;
    rel_t      new_rel;
    logic      to_alu, to_sfu;

    always_comb begin
        st_d    = st_q;
        new_rel = '{v: 1'b1, wid: set_warp, rid: set_reg};
        to_alu  = set_valid && (set_pipe == PIPE_ALU || set_pipe == PIPE_CTRL);
        to_sfu  = set_valid && (set_pipe == PIPE_SFU);

        // release delay lines advance one stage per cycle
        for (int i = ALU_D - 1; i > 0; i--) st_d.alu[i] = st_q.alu[i-1];
        for (int i = SFU_D - 1; i > 0; i--) st_d.sfu[i] = st_q.sfu[i-1];
        st_d.alu[0] = to_alu ? new_rel : '0;
        st_d.sfu[0] = to_sfu ? new_rel : '0;

        // clears: expiring fixed-latency entries and load completions
        if (st_q.alu[ALU_D-1].v)
            st_d.sb[st_q.alu[ALU_D-1].wid][st_q.alu[ALU_D-1].rid] = 1'b0;
        if (st_q.sfu[SFU_D-1].v)
            st_d.sb[st_q.sfu[SFU_D-1].wid][st_q.sfu[SFU_D-1].rid] = 1'b0;
        if (ld_done_valid)
            st_d.sb[ld_done_warp][ld_done_reg] = 1'b0;

        // set: a pending destination can never be reissued, so no clash
        if (set_valid)
            st_d.sb[set_warp][set_reg] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend = st_q.sb;

endmodule

// File: rtl/ws_pipe_ports.sv
module ws_pipe_ports
    import warp_sched_pkg::*;
#(
    parameter int SFU_II  = 4,
    parameter int LSU_II  = 2,
    localparam int MAX_II = (SFU_II > LSU_II) ? SFU_II : LSU_II,
    localparam int BW     = $clog2(MAX_II) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_valid,
    input  pipe_e             issue_pipe,
    output logic [PIPE_N-1:0] busy
);

    typedef struct packed {
        logic [PIPE_N-1:0][BW-1:0] cnt;
    } port_state_t;

    port_state_t st_d, st_q;

    function automatic int ii_of(pipe_e p);
        case (p)
            PIPE_SFU: return SFU_II;
            PIPE_LSU: return LSU_II;
            default:  return 1;
        endcase
    endfunction

    always_comb begin
        st_d = st_q;
        for (int p = 0; p < PIPE_N; p++) begin
            if (issue_valid && issue_pipe == pipe_e'(PIPE_W'(p)))
                st_d.cnt[p] = BW'(ii_of(pipe_e'(PIPE_W'(p))) - 1);
            else if (st_q.cnt[p] != '0)
                st_d.cnt[p] = st_q.cnt[p] - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        for (int p = 0; p < PIPE_N; p++) busy[p] = (st_q.cnt[p] != '0);
    end

endmodule

// File: rtl/ws_rr_arbiter.sv
module ws_rr_arbiter #(
    parameter int N  = 16,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    output logic          gnt_valid,
    output logic [IW-1:0] gnt_id
);

    typedef struct packed {
        logic [IW-1:0] ptr;
    } arb_state_t;

    arb_state_t st_d, st_q;

    always_comb begin
        gnt_valid = 1'b0;
        gnt_id    = '0;
        for (int k = 0; k < N; k++) begin
            int idx;
            idx = (int'(st_q.ptr) + k) % N;
            if (!gnt_valid && req[idx]) begin
                gnt_valid = 1'b1;
                gnt_id    = IW'(idx);
            end
        end
        st_d = st_q;
        if (gnt_valid)
            st_d.ptr = (int'(gnt_id) == N - 1) ? '0 : gnt_id + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched
    import warp_sched_pkg::*;
#(
    parameter int NUM_WARPS = 16,
    parameter int NUM_REGS  = 8,
    parameter int ALU_LAT   = 4,
    parameter int SFU_LAT   = 12,
    parameter int SFU_II    = 4,
    parameter int LSU_II    = 2,
    localparam int WID_W    = $clog2(NUM_WARPS),
    localparam int RID_W    = $clog2(NUM_REGS),
    localparam int CNT_W    = $clog2(NUM_WARPS + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_WARPS-1:0]       warp_active,
    input  logic [NUM_WARPS-1:0]       inst_valid,
    input  logic [NUM_WARPS*RID_W-1:0] inst_src0,
    input  logic [NUM_WARPS*RID_W-1:0] inst_src1,
    input  logic [NUM_WARPS*RID_W-1:0] inst_dst,
    input  logic [NUM_WARPS-1:0]       inst_wr,
    input  logic [NUM_WARPS*2-1:0]     inst_pipe,
    input  logic [NUM_WARPS-1:0]       inst_bar,
    input  logic                       ld_done_valid,
    input  logic [WID_W-1:0]           ld_done_warp,
    input  logic [RID_W-1:0]           ld_done_reg,
    output logic                       issue_valid,
    output logic [WID_W-1:0]           issue_warp,
    output logic [1:0]                 issue_pipe,
    output logic [CNT_W-1:0]           elig_count
);

    typedef struct packed {
        logic [NUM_WARPS-1:0] park;
    } bar_state_t;

    bar_state_t st_d, st_q;

    logic [NUM_WARPS*NUM_REGS-1:0] pend;
    logic [PIPE_N-1:0]             pipe_busy;
    logic [NUM_WARPS-1:0]          elig;
    logic [NUM_WARPS-1:0]          park_now;
    logic                          gnt_valid;
    logic [WID_W-1:0]              gnt_id;
    pipe_e                         gnt_pipe;
    logic                          gnt_wr;
    logic                          gnt_bar;
    logic [RID_W-1:0]              gnt_dst;
    logic                          bar_release;

    // readiness: conjunction of all per-warp conditions
    always_comb begin
        elig       = '0;
        elig_count = '0;
        for (int w = 0; w < NUM_WARPS; w++) begin
            logic [RID_W-1:0] a, b, d;
            pipe_e            p;
            logic             src_hold, dst_hold;
            a = inst_src0[w*RID_W +: RID_W];
            b = inst_src1[w*RID_W +: RID_W];
            d = inst_dst [w*RID_W +: RID_W];
            p = pipe_e'(inst_pipe[w*2 +: 2]);
            src_hold = pend[w*NUM_REGS + int'(a)] || pend[w*NUM_REGS + int'(b)];
            dst_hold = inst_wr[w] && pend[w*NUM_REGS + int'(d)];
            elig[w]  = warp_active[w] && inst_valid[w] && !st_q.park[w]
                    && !src_hold && !dst_hold && !pipe_busy[p];
            elig_count = elig_count + CNT_W'(elig[w]);
        end
    end

    ws_rr_arbiter #(.N(NUM_WARPS)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (elig),
        .gnt_valid (gnt_valid),
        .gnt_id    (gnt_id)
    );

    always_comb begin
        gnt_pipe = pipe_e'(inst_pipe[int'(gnt_id)*2 +: 2]);
        gnt_wr   = inst_wr[gnt_id];
        gnt_bar  = inst_bar[gnt_id];
        gnt_dst  = inst_dst[int'(gnt_id)*RID_W +: RID_W];
    end

    ws_scoreboard #(
        .NUM_WARPS (NUM_WARPS),
        .NUM_REGS  (NUM_REGS),
        .ALU_LAT   (ALU_LAT),
        .SFU_LAT   (SFU_LAT)
    ) u_sb (
        .clk           (clk),
        .rst_n         (rst_n),
        .set_valid     (gnt_valid && gnt_wr),
        .set_warp      (gnt_id),
        .set_reg       (gnt_dst),
        .set_pipe      (gnt_pipe),
        .ld_done_valid (ld_done_valid),
        .ld_done_warp  (ld_done_warp),
        .ld_done_reg   (ld_done_reg),
        .pend          (pend)
    );

    ws_pipe_ports #(
        .SFU_II (SFU_II),
        .LSU_II (LSU_II)
    ) u_ports (
        .clk         (clk),
        .rst_n       (rst_n),
        .issue_valid (gnt_valid),
        .issue_pipe  (gnt_pipe),
        .busy        (pipe_busy)
    );

    // barrier parking: group is the resident set
    always_comb begin
        st_d        = st_q;
        bar_release = (|warp_active) && ((st_q.park & warp_active) == warp_active);
        if (bar_release)
            st_d.park = '0;
        if (gnt_valid && gnt_bar)
            st_d.park[gnt_id] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign park_now    = st_q.park;
    assign issue_valid = gnt_valid;
    assign issue_warp  = gnt_id;
    assign issue_pipe  = gnt_pipe;

endmodule

// File: rtl/ws_sched_checks.sv
module ws_sched_checks #(
    parameter int NUM_WARPS = 16,
    localparam int WID_W    = $clog2(NUM_WARPS),
    localparam int CNT_W    = $clog2(NUM_WARPS + 1)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 issue_valid,
    input logic [WID_W-1:0]     issue_warp,
    input logic [1:0]           issue_pipe,
    input logic [CNT_W-1:0]     elig_count,
    input logic [NUM_WARPS-1:0] park,
    input logic [3:0]           pipe_busy
);

    logic             prev_v_q;
    logic [WID_W-1:0] prev_w_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_v_q <= 1'b0;
            prev_w_q <= '0;
        end else begin
            prev_v_q <= issue_valid;
            prev_w_q <= issue_warp;
        end
    end

    a_r1_issue_has_candidate: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> elig_count != '0);

    a_r1_idle_without_candidate: assert property (@(posedge clk) disable iff (!rst_n)
        (elig_count == '0) |-> !issue_valid);

    a_r8_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        int'(elig_count) <= NUM_WARPS);

    a_r3_previous_lowest: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && prev_v_q && elig_count > 1) |-> issue_warp != prev_w_q);

    a_r7_parked_never_issues: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> !park[issue_warp]);

    a_r5_port_open_on_issue: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> !pipe_busy[issue_pipe]);

endmodule

bind warp_issue_sched ws_sched_checks #(.NUM_WARPS(NUM_WARPS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .issue_valid (issue_valid),
    .issue_warp  (issue_warp),
    .issue_pipe  (issue_pipe),
    .elig_count  (elig_count),
    .park        (park_now),
    .pipe_busy   (pipe_busy)
);

// File: tb/sim_warp_issue_sched.sv
`timescale 1ns/1ps
module sim_warp_issue_sched;

    localparam int NW = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] active, ival, iwr, ibar;
    logic [47:0] s0, s1, dst;
    logic [31:0] pipe;
    logic        ld_v;
    logic [3:0]  ld_w;
    logic [2:0]  ld_r;
    logic        issue_valid;
    logic [3:0]  issue_warp;
    logic [1:0]  issue_pipe;
    logic [4:0]  elig_count;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    warp_issue_sched u0 (
        .clk(clk), .rst_n(rst_n), .warp_active(active), .inst_valid(ival),
        .inst_src0(s0), .inst_src1(s1), .inst_dst(dst), .inst_wr(iwr),
        .inst_pipe(pipe), .inst_bar(ibar), .ld_done_valid(ld_v),
        .ld_done_warp(ld_w), .ld_done_reg(ld_r), .issue_valid(issue_valid),
        .issue_warp(issue_warp), .issue_pipe(issue_pipe), .elig_count(elig_count)
    );

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int who();
        return issue_valid ? int'(issue_warp) : -1;
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic samp();
        #1;
    endtask

    task automatic put(int w, bit v, int a, int b, int d, bit wr, int p, bit bar);
        ival[w]          = v;
        s0[w*3 +: 3]     = 3'(a);
        s1[w*3 +: 3]     = 3'(b);
        dst[w*3 +: 3]    = 3'(d);
        iwr[w]           = wr;
        pipe[w*2 +: 2]   = 2'(p);
        ibar[w]          = bar;
    endtask

    task automatic do_reset(logic [15:0] act);
        @(negedge clk);
        rst_n = 1'b0;
        ival = '0; iwr = '0; ibar = '0; s0 = '0; s1 = '0; dst = '0; pipe = '0;
        ld_v = 1'b0; ld_w = '0; ld_r = '0;
        active = act;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // from a sample point of cycle 1, count cycles until warp w issues
    task automatic wait_issue(int w, int lim, output int k);
        k = 1;
        while (!(issue_valid && int'(issue_warp) == w) && k < lim) begin
            tick();
            samp();
            k++;
        end
    endtask

    task automatic t_reset_state();
        do_reset(16'hFFFF);
        samp();
        chk("R9 idle after reset issue_valid", int'(issue_valid), 0);
        chk("R9 idle after reset elig_count", int'(elig_count), 0);
        tick();
        put(9, 1, 1, 2, 3, 1, 0, 0);
        put(0, 1, 1, 2, 3, 1, 0, 0);
        samp();
        chk("R9 pointer at warp 0 after reset", who(), 0);
        chk("R8 two eligible after reset", int'(elig_count), 2);
        chk("R1 pipe code echoed", int'(issue_pipe), 0);
        tick();
    endtask

    task automatic t_round_robin();
        do_reset(16'hFFFF);
        put(0, 1, 0, 0, 0, 0, 0, 0);
        put(1, 1, 0, 0, 0, 0, 0, 0);
        put(2, 1, 0, 0, 0, 0, 0, 0);
        for (int i = 0; i < 6; i++) begin
            samp();
            chk("R3 rotation order", who(), i % 3);
            chk("R8 three eligible", int'(elig_count), 3);
            tick();
        end
    endtask

    task automatic t_lowest_priority();
        do_reset(16'hFFFF);
        put(5, 1, 0, 0, 0, 0, 0, 0);
        samp();
        chk("R3 lone warp issues", who(), 5);
        tick();
        samp();
        chk("R3 lone warp re-picked", who(), 5);
        tick();
        put(2, 1, 0, 0, 0, 0, 0, 0);
        samp();
        chk("R3 last issuer yields", who(), 2);
        tick();
        samp();
        chk("R3 alternation back", who(), 5);
        tick();
        samp();
        chk("R3 alternation again", who(), 2);
        tick();
    endtask

    task automatic t_alu_raw();
        int k;
        do_reset(16'hFFFF);
        put(0, 1, 0, 0, 3, 1, 0, 0);
        samp();
        chk("R4 producer issues", who(), 0);
        tick();
        put(0, 1, 3, 1, 4, 1, 0, 0);
        samp();
        chk("R2 RAW blocks next cycle", int'(elig_count), 0);
        wait_issue(0, 20, k);
        chk("R4 RAW distance cycles", k, 4);
        tick();
        put(0, 1, 0, 0, 4, 1, 0, 0);
        samp();
        wait_issue(0, 20, k);
        chk("R2 WAW destination wait", k, 4);
        tick();
        put(0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic t_sfu();
        int k;
        do_reset(16'hFFFF);
        put(0, 1, 0, 0, 1, 1, 1, 0);
        put(1, 1, 0, 0, 0, 0, 1, 0);
        samp();
        chk("R5 sfu producer issues", who(), 0);
        chk("R1 sfu pipe code", int'(issue_pipe), 1);
        tick();
        put(0, 1, 1, 1, 2, 1, 0, 0);
        samp();
        chk("R5 sfu port closed", int'(elig_count), 0);
        wait_issue(1, 20, k);
        chk("R5 sfu issue interval", k, 4);
        tick();
        put(1, 0, 0, 0, 0, 0, 0, 0);
        samp();
        wait_issue(0, 30, k);
        chk("R5 sfu result latency", k + 4, 12);
        tick();
        put(0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic t_load();
        do_reset(16'hFFFF);
        put(3, 1, 0, 0, 5, 1, 2, 0);
        put(4, 1, 0, 0, 0, 0, 2, 0);
        samp();
        chk("R6 load issues", who(), 3);
        tick();
        put(3, 1, 5, 0, 0, 0, 0, 0);
        samp();
        chk("R5 lsu port closed", int'(elig_count), 0);
        tick();
        samp();
        chk("R5 lsu interval two", who(), 4);
        tick();
        put(4, 0, 0, 0, 0, 0, 0, 0);
        repeat (20) tick();
        samp();
        chk("R6 still pending without pulse", int'(elig_count), 0);
        tick();
        ld_v = 1; ld_w = 4'd4; ld_r = 3'd5;
        tick();
        ld_w = 4'd3; ld_r = 3'd6;
        tick();
        ld_v = 0;
        samp();
        chk("R6 mismatched pulses ignored", int'(elig_count), 0);
        tick();
        ld_v = 1; ld_w = 4'd3; ld_r = 3'd5;
        samp();
        chk("R6 no bypass in pulse cycle", int'(elig_count), 0);
        tick();
        ld_v = 0;
        samp();
        chk("R6 dependent issues after pulse", who(), 3);
        tick();
        put(3, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic t_barrier();
        do_reset(16'h0007);
        put(0, 1, 0, 0, 0, 0, 0, 1);
        put(1, 1, 0, 0, 0, 0, 0, 1);
        put(2, 1, 0, 0, 0, 0, 0, 1);
        put(5, 1, 0, 0, 0, 0, 0, 0);
        samp();
        chk("R2 non-resident excluded", int'(elig_count), 3);
        chk("R7 first arrival", who(), 0);
        tick();
        put(0, 1, 0, 0, 0, 0, 0, 0);
        samp();
        chk("R7 parked warp not counted", int'(elig_count), 2);
        chk("R7 second arrival", who(), 1);
        tick();
        put(1, 1, 0, 0, 0, 0, 0, 0);
        samp();
        chk("R7 last arrival", who(), 2);
        tick();
        put(2, 1, 0, 0, 0, 0, 0, 0);
        samp();
        chk("R7 all parked count", int'(elig_count), 0);
        chk("R7 all parked no issue", int'(issue_valid), 0);
        tick();
        samp();
        chk("R7 group released count", int'(elig_count), 3);
        chk("R7 released issue wraps", who(), 0);
        tick();
    endtask

    task automatic t_same_edge();
        int k;
        do_reset(16'hFFFF);
        put(0, 1, 0, 0, 5, 1, 2, 0);
        samp();
        chk("R10 load producer", who(), 0);
        tick();
        put(0, 1, 0, 0, 2, 1, 0, 0);
        samp();
        chk("R10 alu producer", who(), 0);
        tick();
        put(0, 1, 2, 5, 6, 1, 0, 0);
        samp();
        chk("R10 dependent waits", int'(elig_count), 0);
        tick();
        tick();
        put(1, 1, 0, 0, 2, 1, 0, 0);
        ld_v = 1; ld_w = 4'd0; ld_r = 3'd5;
        samp();
        chk("R10 other warp sets same index", who(), 1);
        tick();
        ld_v = 0;
        put(1, 1, 2, 2, 0, 0, 0, 0);
        samp();
        chk("R10 both clears applied", who(), 0);
        chk("R10 new set kept", int'(elig_count), 1);
        tick();
        put(0, 0, 0, 0, 0, 0, 0, 0);
        samp();
        wait_issue(1, 20, k);
        chk("R4 other warp full latency", k, 3);
        tick();
    endtask

    initial begin
        #1000000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_round_robin();
        t_lowest_priority();
        t_alu_raw();
        t_sfu();
        t_load();
        t_barrier();
        t_same_edge();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule